// File: doc/BRIEF.md
# Logic and Shift Execution Unit

This block is a 32-bit execution slice for the integer pipe of a RISC-style core. Each cycle it may accept two register operands and an operation select. It computes one of six bitwise logic functions or one of three word shifts. The result appears on the outputs one cycle later, qualified by an output valid.

An optional record form also updates a 4-bit condition field. This field holds the signed sign and zero status of the result, together with a copy of a sticky summary-overflow input. For the algebraic right shift, a carry output reports whether a negative operand lost any 1 bits. Decode, the register file, arithmetic and rotate operations are outside this block.

Top module: `logic_shift_unit`

## Requirements
- R1: The six logic functions use these `op_sel` codes: 0 is a OR b, 1 is a OR NOT b, 2 is a XOR b, 3 is NOT(a AND b), 4 is NOT(a OR b), 5 is NOT(a XOR b).
- R2: Code 6 shifts a left and code 7 shifts a right logically, each filling with zeros. The amount is the low 6 bits of b. Any amount from 32 to 63 gives a result of zero.
- R3: Code 8 shifts a right and fills with copies of bit 31. Any amount from 32 to 63 fills the whole word with bit 31.
- R4: For code 8, `carry` is 1 only when bit 31 of a is set and at least one 1 bit was shifted out. For every other code, `carry` is 0.
- R5: When `rec_en` is 1 on an accepted operation, `cond` is rewritten. Bit 3 is set when the result is negative as a signed value. Bit 2 is set when the result is positive and nonzero. Bit 1 is set when the result is zero. Bit 0 takes the value of `so_in`.
- R6: When `rec_en` is 0 on an accepted operation, `cond` keeps its previous value.
- R7: `out_valid` is high exactly one cycle after `in_valid` was high. While `in_valid` is low, `result`, `carry` and `cond` hold their values.
- R8: A synchronous reset clears `out_valid`, `result`, `carry` and `cond`.
- R9: Codes 9 to 15 give a result of zero with `carry` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 4 | Operation code |
| rec_en | input | 1 | Record form: update the condition field |
| src_a | input | 32 | First operand (value being shifted) |
| src_b | input | 32 | Second operand (shift amount in the low 6 bits) |
| so_in | input | 1 | Sticky summary-overflow status |
| out_valid | output | 1 | Result outputs are valid |
| result | output | 32 | Registered result |
| cond | output | 4 | Condition field: less, greater, equal, summary overflow |
| carry | output | 1 | Carry from the algebraic right shift |

## Verification
The bench builds the unit with its default width of 32, so the shift amount field is 6 bits wide. At this width every shift amount from 0 to 63 can be reached, including the 32-to-63 range that clears or sign-fills the word. Random operands and codes cover all sixteen select values. Directed cases cover zero and negative results, and algebraic shifts that do and do not lose 1 bits.

// File: rtl/logic_shift_unit.sv
module logic_shift_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op_sel,
  input  logic         rec_en,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         so_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [3:0]   cond,
  output logic         carry
);
  localparam int SH = $clog2(W) + 1;

  logic [SH-1:0] amt;
  logic          big;
  logic [SH-2:0] n;
  logic          sgn;
  logic [W-1:0]  lost;
  logic [W-1:0]  res_d;
  logic          cy_d;

  assign amt  = src_b[SH-1:0];
  assign big  = amt[SH-1];
  assign n    = amt[SH-2:0];
  assign sgn  = src_a[W-1];
  assign lost = big ? src_a : (src_a & ~({W{1'b1}} << n));

  always_comb begin
    res_d = '0;
    cy_d  = 1'b0;
    case (op_sel)
      4'd0: res_d = src_a | src_b;
      4'd1: res_d = src_a | ~src_b;
      4'd2: res_d = src_a ^ src_b;
      4'd3: res_d = ~(src_a & src_b);
      4'd4: res_d = ~(src_a | src_b);
      4'd5: res_d = ~(src_a ^ src_b);
      4'd6: res_d = big ? '0 : (src_a << n);
      4'd7: res_d = big ? '0 : (src_a >> n);
      4'd8: begin
        res_d = big ? {W{sgn}} : W'($signed(src_a) >>> n);
        cy_d  = sgn & (|lost);
      end
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry     <= 1'b0;
      cond      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_d;
        carry  <= cy_d;
        if (rec_en)
          cond <= {res_d[W-1], ~res_d[W-1] & (|res_d), ~(|res_d), so_in};
      end
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r7_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(cond) && $stable(carry)));
  a_r6_cond_held: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rec_en) |=> $stable(cond));
  a_r5_one_relation: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rec_en) |=> ($countones(cond[3:1]) == 1 && cond[1] == (result == '0)));
  a_r4_carry_negative: assert property (@(posedge clk) disable iff (rst)
    carry |-> result[W-1]);
  a_r4_carry_only_sraw: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel != 4'd8) |=> !carry);
endmodule

// File: tb/logic_shift_unit_tb.sv
module logic_shift_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op_sel;
  logic        rec_en;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic        so_in;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  cond;
  logic        carry;

  int total = 0;
  int bad = 0;
  logic [3:0] cond_m;

  always #5 clk = ~clk;

  logic_shift_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .rec_en(rec_en),
    .src_a(src_a), .src_b(src_b), .so_in(so_in), .out_valid(out_valid),
    .result(result), .cond(cond), .carry(carry)
  );

  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic c;
    int k;
    k = int'(b[5:0]);
    r = 32'h0;
    c = 1'b0;
    case (op)
      4'd0: r = a | b;
      4'd1: r = a | ~b;
      4'd2: r = a ^ b;
      4'd3: r = ~(a & b);
      4'd4: r = ~(a | b);
      4'd5: r = ~(a ^ b);
      4'd6: begin r = a; for (int i = 0; i < k; i++) r = {r[30:0], 1'b0}; end
      4'd7: begin r = a; for (int i = 0; i < k; i++) r = {1'b0, r[31:1]}; end
      4'd8: begin
        r = a;
        for (int i = 0; i < k; i++) begin
          if (r[0] && a[31]) c = 1'b1;
          r = {a[31], r[31:1]};
        end
      end
      default: r = 32'h0;
    endcase
    return {c, r};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic rec, input logic so);
    logic [32:0] m;
    logic [31:0] held;
    m = model(op, a, b);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; rec_en = rec; so_in = so;
    @(negedge clk);
    in_valid = 1'b0;
    if (rec) cond_m = {m[31], ~m[31] & (|m[31:0]), ~(|m[31:0]), so};
    chk("R7 valid", {31'b0, out_valid}, 32'h1);
    if (op <= 4'd5) chk("R1 logic", result, m[31:0]);
    else if (op <= 4'd7) chk("R2 shift", result, m[31:0]);
    else if (op == 4'd8) chk("R3 sraw", result, m[31:0]);
    else chk("R9 undefined", result, 32'h0);
    chk("R4 carry", {31'b0, carry}, {31'b0, m[32]});
    if (rec) chk("R5 record", {28'b0, cond}, {28'b0, cond_m});
    else chk("R6 cond held", {28'b0, cond}, {28'b0, cond_m});
    held = result;
    @(negedge clk);
    chk("R7 idle valid", {31'b0, out_valid}, 32'h0);
    chk("R7 hold", result, held);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; op_sel = 4'd0; rec_en = 1'b0;
    src_a = '0; src_b = '0; so_in = 1'b0; cond_m = 4'h0;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", {31'b0, out_valid}, 32'h0);
    chk("R8 reset result", result, 32'h0);
    chk("R8 reset cond", {28'b0, cond}, 32'h0);
    chk("R8 reset carry", {31'b0, carry}, 32'h0);
    rst = 1'b0;
    // directed cases
    run(4'd0, 32'h1234, 32'h5678, 1'b1, 1'b0);
    run(4'd1, 32'h1234, 32'h5678, 1'b1, 1'b1);
    run(4'd2, 32'h1234, 32'h5678, 1'b0, 1'b0);
    run(4'd3, 32'h1234, 32'h5678, 1'b1, 1'b0);
    run(4'd4, 32'h1234, 32'h5678, 1'b0, 1'b1);
    run(4'd5, 32'h1234, 32'h5678, 1'b1, 1'b0);
    run(4'd6, 32'h80, 32'd16, 1'b1, 1'b0);
    run(4'd6, 32'h80, 32'd32, 1'b1, 1'b0);
    run(4'd7, 32'h0080_0000, 32'd16, 1'b0, 1'b0);
    run(4'd7, 32'h0080_0000, 32'd63, 1'b1, 1'b1);
    run(4'd8, 32'h8000_0000, 32'd3, 1'b1, 1'b0);
    run(4'd8, 32'h8000, 32'd3, 1'b1, 1'b0);
    run(4'd8, 32'h8000_0004, 32'd3, 1'b1, 1'b0);
    run(4'd8, 32'h8000_0000, 32'd40, 1'b1, 1'b0);
    run(4'd8, 32'h7fff_ffff, 32'd33, 1'b1, 1'b0);
    run(4'd6, 32'hffff_ffff, 32'd0, 1'b0, 1'b0);
    run(4'd11, 32'hdead_beef, 32'h1, 1'b1, 1'b0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      ra = $urandom;
      rb = $urandom;
      if (i % 5 == 0) ra = 32'h0;
      run(4'($urandom % 16), ra, rb, 1'($urandom), 1'($urandom));
    end
    // reset in operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 reset cond again", {28'b0, cond}, 32'h0);
    chk("R8 reset result again", result, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule